// File: doc/BRIEF.md
# Reloadable Baud Tick Generator

This block produces the sixteen-times-oversampling strobe that paces an asynchronous serial transmitter and receiver. Software programs it through a small write-only register port. One register holds a 13-bit reload value. The other is a control word carrying a run bit, a prescale-select bit and a fractional-enable bit. The system clock first passes through a prescaler that divides by two or by three. The prescaled strobe then steps a down-counter. Each time that counter passes through zero, the block raises a one-clock `tick` and reloads the counter.

The reload value is protected. It can only be written while the generator is stopped. To change the rate, software clears the run bit, writes the new reload value, then sets the run bit again. The fractional-enable bit is decoded but has no effect. The generator always runs as an integer divider, and software is expected to leave that bit clear.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the run bit is clear, the prescale-select bit is clear, the reload value is 0 and `tick` is low. Setting only the run bit then gives a tick period of 2 clocks.
- R2: A write with `wr_addr` = 0x50 targets the reload register, which keeps `wr_data[12:0]`. A write with `wr_addr` = 0x10 targets the control register: bit 15 is run, bit 8 is prescale select and bit 9 is fractional enable. Writes to any other address change nothing.
- R3: While the run bit is clear, `tick` stays low. Clearing the run bit stops ticks from the next cycle on.
- R4: With prescale select = 0, the tick period is 2 × (reload + 1) clocks.
- R5: With prescale select = 1, the tick period is 3 × (reload + 1) clocks.
- R6: Let P be the tick period. When a control write sets the run bit at clock edge E, the first tick is high in the cycle that ends P edges after E, and every P-th cycle after that.
- R7: A reload write taken while the run bit is set is ignored. A later restart still uses the value stored before that write.
- R8: Setting the fractional-enable bit has no effect on the tick period or phase.
- R9: `tick` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 8 | Register byte offset |
| wr_data | input | 16 | Register write data |
| tick | output | 1 | One-cycle oversampling strobe |

## Verification
The assertions assume that software never changes the prescale select while the generator runs, and that the run bit is only set from the stopped state. Under those conditions the counter and prescaler phases are always fresh when counting begins. The stimulus follows the same discipline for every setting. It stops the generator before each new reload, prescale or fractional setting, and only then starts it again. The deliberately ignored reload write and the writes to unmapped addresses are the only writes issued while the generator is running.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;
  localparam int unsigned BT_DATA_W   = 16;
  localparam int unsigned BT_ADDR_W   = 8;
  localparam int unsigned BT_RELOAD_W = 13;
  localparam int unsigned BT_RUN_BIT  = 15;
  localparam int unsigned BT_PSEL_BIT = 8;
  localparam int unsigned BT_FRAC_BIT = 9;
  localparam logic [7:0]  BT_CTRL_OFS   = 8'h10;
  localparam logic [7:0]  BT_RELOAD_OFS = 8'h50;

  // last prescaler count before the strobe: divide by 2 or by 3
  function automatic logic [1:0] pre_last(input logic psel);
    return psel ? 2'd2 : 2'd1;
  endfunction

  // full tick period in system clocks
  function automatic int unsigned tick_period(input logic psel,
                                              input int unsigned reload);
    return (int'(pre_last(psel)) + 1) * (reload + 1);
  endfunction
endpackage

// File: rtl/bt_regs.sv
module bt_regs
  import baud_tick_pkg::*;
#(
  parameter int unsigned DATA_W   = BT_DATA_W,
  parameter int unsigned ADDR_W   = BT_ADDR_W,
  parameter int unsigned RELOAD_W = BT_RELOAD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic                run,
  output logic                psel,
  output logic [RELOAD_W-1:0] reload
);
  logic ctrl_hit, reload_hit, reload_take, frac_req;

  assign ctrl_hit    = wr_en && (wr_addr == ADDR_W'(BT_CTRL_OFS));
  assign reload_hit  = wr_en && (wr_addr == ADDR_W'(BT_RELOAD_OFS));
  assign reload_take = reload_hit && !run;
  // fractional mode is decoded only; it never reaches the datapath
  assign frac_req    = ctrl_hit && wr_data[BT_FRAC_BIT];

  wire unused_ok = ^{wr_data, frac_req};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b0;
      psel   <= 1'b0;
      reload <= '0;
    end else begin
      if (ctrl_hit) begin
        run  <= wr_data[BT_RUN_BIT];
        psel <= wr_data[BT_PSEL_BIT];
      end
      if (reload_take) reload <= wr_data[RELOAD_W-1:0];
    end
  end

  // R7
  reload_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(reload));
endmodule

// File: rtl/bt_prescaler.sv
module bt_prescaler
  import baud_tick_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic psel,
  output logic pre_stb
);
  logic [1:0] pre_cnt;
  logic [1:0] last;

  assign last    = pre_last(psel);
  assign pre_stb = run && (pre_cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) pre_cnt <= '0;
    else if (pre_cnt == last) pre_cnt <= '0;
    else pre_cnt <= pre_cnt + 2'd1;
  end

  // R4
  pre_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_stb |=> (pre_cnt == 2'd0));
  // R5
  pre_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt <= 2'd2);
endmodule

// File: rtl/bt_counter.sv
module bt_counter #(
  parameter int unsigned RELOAD_W = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                pre_stb,
  input  logic [RELOAD_W-1:0] reload,
  output logic                zero_hit
);
  logic [RELOAD_W-1:0] cnt;

  assign zero_hit = run && pre_stb && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (!run) cnt <= reload;
    else if (pre_stb) cnt <= (cnt == '0) ? reload : cnt - 1'b1;
  end

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pre_stb && cnt != '0) |=> (!run || cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int unsigned DATA_W   = BT_DATA_W,
  parameter int unsigned ADDR_W   = BT_ADDR_W,
  parameter int unsigned RELOAD_W = BT_RELOAD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tick
);
  logic                run, psel, pre_stb, zero_hit;
  logic [RELOAD_W-1:0] reload;

  bt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RELOAD_W(RELOAD_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .run(run), .psel(psel), .reload(reload));

  bt_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .psel(psel), .pre_stb(pre_stb));

  bt_counter #(.RELOAD_W(RELOAD_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .pre_stb(pre_stb),
    .reload(reload), .zero_hit(zero_hit));

  assign tick = zero_hit;

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);
  // R9
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        tick;
  int checks = 0;
  int failures = 0;

  always #5ns clk = ~clk;

  baud_tick_gen uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .tick(tick));

  function automatic int unsigned exp_period(bit sel, int unsigned r);
    int unsigned div;
    div = sel ? 3 : 2;
    return div * (r + 1);
  endfunction

  function automatic logic [15:0] ctrl_word(bit go, bit sel, bit frac);
    logic [15:0] w;
    w = '0;
    w[15] = go; w[8] = sel; w[9] = frac;
    return w;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // called right after wr(): current negedge is k=1 after the write edge
  task automatic watch(input string req, input int unsigned per,
                       input int unsigned len);
    int bad = 0;
    logic got_b = 0, exp_b = 0;
    int at = 0;
    for (int k = 1; k <= int'(len); k++) begin
      logic e;
      if (k > 1) @(negedge clk);
      e = (per != 0) && (k % per == 0);
      if (tick !== e && bad == 0) begin got_b = tick; exp_b = e; at = k; end
      if (tick !== e) bad++;
    end
    checks++;
    if (bad != 0) begin
      failures++;
      $display("FAIL %s: cycle %0d tick=%b expected %b (period %0d)",
               req, at, got_b, exp_b, per);
    end
  endtask

  task automatic stop_gen();
    wr(8'h10, 16'h0000);
  endtask

  initial begin
    #(10ns * 200000);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 R3: quiet after reset
    watch("R1", 0, 20);
    // R1: default reload 0, divide by 2
    wr(8'h10, ctrl_word(1, 0, 0));
    watch("R1", exp_period(0, 0), 12);
    // R3: stop -> quiet
    stop_gen();
    watch("R3", 0, 30);
    // R4 R6 R9
    wr(8'h50, 16'd4);
    wr(8'h10, ctrl_word(1, 0, 0));
    watch("R4", exp_period(0, 4), 40);
    stop_gen();
    // R5 with reload 0 (tick every 3, single-cycle)
    wr(8'h50, 16'd0);
    wr(8'h10, ctrl_word(1, 1, 0));
    watch("R5", exp_period(1, 0), 15);
    stop_gen();
    // R2: upper bits dropped -> 0x1FFF
    wr(8'h50, 16'hFFFF);
    wr(8'h10, ctrl_word(1, 0, 0));
    watch("R2", exp_period(0, 13'h1FFF), 2 * exp_period(0, 13'h1FFF) + 2);
    stop_gen();
    // R7: reload write while running ignored
    wr(8'h50, 16'd5);
    wr(8'h10, ctrl_word(1, 0, 0));
    wr(8'h50, 16'd9);
    stop_gen();
    wr(8'h10, ctrl_word(1, 0, 0));
    watch("R7", exp_period(0, 5), 40);
    // R2: unmapped addresses ignored (while running, and when stopped)
    wr(8'h54, 16'd2);
    stop_gen();
    wr(8'h20, ctrl_word(1, 1, 0));
    watch("R2", 0, 30);
    wr(8'h10, ctrl_word(1, 0, 0));
    watch("R2", exp_period(0, 5), 40);
    stop_gen();
    // R8: fractional bit has no effect
    wr(8'h50, 16'd3);
    wr(8'h10, ctrl_word(1, 1, 1));
    watch("R8", exp_period(1, 3), 40);
    stop_gen();
    // random settings
    for (int i = 0; i < 12; i++) begin
      int unsigned r;
      bit s, f;
      r = $urandom_range(0, 200);
      s = 1'($urandom_range(0, 1));
      f = 1'($urandom_range(0, 1));
      wr(8'h50, 16'(r));
      wr(8'h10, ctrl_word(1, s, f));
      watch(s ? "R5" : "R4", exp_period(s, r), 3 * exp_period(s, r) + 2);
      stop_gen();
      watch("R3", 0, 5);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule